// File: doc/BRIEF.md
# Rename Stage Stall and Skid Controller

This block is the flow control of a register-rename pipeline stage. Decode hands it a group of up to `W` instructions each cycle. For each group the controller works out how many instructions it may pass on to issue. The limits are the reorder-buffer and issue-queue credits, which are corrected for the feedback latency, and the count of free physical registers. The renaming datapath is not part of the block. It sees the per-slot destination count and a forward mask that tells it which slots to consume in the current cycle.

When the stage cannot take everything it is offered, it parks the group in a small skid buffer and raises a stall towards decode. Later it resumes inside the parked group at the slot where it stopped, and it keeps decode stalled until every parked group has drained. A squash from commit discards all parked work and puts the controller into a squashing state until both squash indications drop.

The state encoding on `state_o` is 0 = Running, 1 = Blocked, 2 = Unblocking, 3 = Squashing. The slot fields are laid out as follows: slot `j` of a group is bit `j` of `dec_sq` and `fwd_mask`, and its destination count is `dec_ndst[j*DW +: DW]`.

Top module: `rn_ctrl`

## Requirements
- R1: After reset `state_o` is 0 (Running), `stall_o` is low, `skid_lvl` is 0 and `fwd_mask` is zero.
- R2: The usable credit for each of the reorder buffer and the issue queue is the reported free count minus `W*FB_DELAY`. When instructions are pending and the smaller of the two usable credits is zero or negative, nothing is forwarded, `stall_o` is high in that cycle and the state becomes 1.
- R3: When the smaller usable credit is positive but less than the number of pending instructions, only that many slots are considered, and the stage blocks at the end of the cycle (stall high, state becomes 1).
- R4: A slot whose squashed flag is set uses up one credit and advances the slot position, but its `fwd_mask` bit stays 0.
- R5: Slots are taken in ascending order. Before the first non-squashed slot whose destination count is greater than the physical registers still free (the free count minus the destinations of slots already forwarded in that cycle), forwarding stops and the stage blocks.
- R6: Whenever the stage blocks, the non-empty decode group of that cycle is appended to the skid buffer. In state 1 every non-empty decode group is appended, `stall_o` is high and nothing is forwarded.
- R7: State 1 moves on only when `down_stall` is low, both usable credits are positive and `preg_free` is non-zero. It goes to 2 if the skid buffer holds a group and to 0 otherwise.
- R8: In state 2 the slots come from the oldest skid group, starting at the saved slot position, and `fwd_from_skid` is high. A cycle that does not block removes that group, also appends any non-empty decode group, keeps `stall_o` high while groups remain and returns to state 0 once the buffer is empty.
- R9: A cycle with `cm_squash` or `rob_squashing` high forwards nothing, keeps `stall_o` low, empties the skid buffer, zeroes the slot position and sets the state to 3. In state 3, the first cycle with both indications low is handled as a Running cycle.
- R10: The saved slot position returns to 0 only after a cycle that ends without blocking. A blocking cycle saves the position just past the last slot consumed.
- R11: With `down_stall` high in states 0, 2 or 3 (and no squash), nothing is forwarded, the stage blocks and the state becomes 1.
- R12: The skid buffer holds `SKID_DEPTH` groups, and a push into a full buffer with no pop in the same cycle is flagged as an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dec_cnt | input | IW | Number of valid slots in the decode group (0..W) |
| dec_sq | input | W | Squashed flag per decode slot |
| dec_ndst | input | W*DW | Destination register count per decode slot |
| rob_free | input | CW | Reported free reorder-buffer entries |
| iq_free | input | CW | Reported free issue-queue entries |
| preg_free | input | CW | Free physical registers this cycle |
| down_stall | input | 1 | Stall request from a downstream stage |
| cm_squash | input | 1 | Squash request from commit |
| rob_squashing | input | 1 | Reorder buffer is still squashing |
| stall_o | output | 1 | Stall to decode |
| fwd_mask | output | W | Slots of the source group forwarded this cycle |
| fwd_from_skid | output | 1 | Source group is the oldest skid entry |
| state_o | output | 2 | Controller state (encoding above) |
| skid_lvl | output | LW | Groups held in the skid buffer |

## Verification
`stall_o`, `fwd_mask` and `fwd_from_skid` are combinational in the current state and inputs, so they are due in the same cycle as the stimulus. `state_o` and `skid_lvl` reflect a decision one rising edge later. The bench drives inputs on the falling edge and compares all five outputs 3 ns later against a queue-based reference model evaluated on the same inputs. It then commits the model's next state at the following rising edge, which keeps each comparison aligned with that single register stage. Decode traffic follows the stall with one cycle of lag, and now and then it ignores the stall, so that groups also arrive while the stage is Blocked and Unblocking.

// File: rtl/rn_pkg.sv
package rn_pkg;

  typedef enum logic [1:0] {
    RN_RUN = 2'd0,
    RN_BLK = 2'd1,
    RN_UNB = 2'd2,
    RN_SQ  = 2'd3
  } rn_state_e;

  // credit left after subtracting what may already be in flight
  function automatic int usable_credit(input int free_cnt, input int width, input int delay);
    return free_cnt - width * delay;
  endfunction

  function automatic int min_int(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/rn_skid.sv
module rn_skid #(
  parameter int GW    = 8,
  parameter int DEPTH = 4,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic [GW-1:0] din,
  output logic [GW-1:0] head,
  output logic [LW-1:0] lvl,
  output logic          full
);
  logic [GW-1:0] mem [DEPTH];
  logic [PW-1:0] rd_q, wr_q;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] nxt_ptr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign full    = (lvl == LW'(DEPTH));
  assign do_pop  = pop && (lvl != '0);
  assign do_push = push && (!full || do_pop);
  assign head    = mem[rd_q];

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wr_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
      wr_q <= '0;
      lvl  <= '0;
    end else if (clr) begin
      rd_q <= '0;
      wr_q <= '0;
      lvl  <= '0;
    end else begin
      if (do_push) wr_q <= nxt_ptr(wr_q);
      if (do_pop)  rd_q <= nxt_ptr(rd_q);
      lvl <= lvl + LW'(do_push) - LW'(do_pop);
    end
  end
endmodule

// File: rtl/rn_admit.sv
module rn_admit #(
  parameter int W  = 4,
  parameter int DW = 2,
  parameter int IW = 3,
  parameter int CW = 6
) (
  input  logic [W-1:0]    sq,
  input  logic [W*DW-1:0] nd,
  input  logic [IW-1:0]   start,
  input  logic [IW-1:0]   lim,
  input  logic [CW-1:0]   preg,
  output logic [W-1:0]    mask,
  output logic [IW-1:0]   ncons,
  output logic            preg_short
);
  int   rem, n;
  logic go;

  always_comb begin
    mask       = '0;
    preg_short = 1'b0;
    rem        = int'(preg);
    n          = 0;
    go         = 1'b1;
    for (int j = 0; j < W; j++) begin
      if (go && j >= int'(start) && j < int'(start) + int'(lim)) begin
        if (sq[j]) begin
          n = n + 1;
        end else if (int'(nd[j*DW +: DW]) > rem) begin
          preg_short = 1'b1;
          go         = 1'b0;
        end else begin
          mask[j] = 1'b1;
          rem     = rem - int'(nd[j*DW +: DW]);
          n       = n + 1;
        end
      end
    end
    ncons = IW'(n);
  end
endmodule

// File: rtl/rn_ctrl.sv
module rn_ctrl
  import rn_pkg::*;
#(
  parameter int W          = 4,
  parameter int DW         = 2,
  parameter int CW         = 6,
  parameter int FB_DELAY   = 2,
  parameter int SKID_DEPTH = 4,
  localparam int IW = $clog2(W + 1),
  localparam int GW = IW + W + W * DW,
  localparam int LW = $clog2(SKID_DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IW-1:0]   dec_cnt,
  input  logic [W-1:0]    dec_sq,
  input  logic [W*DW-1:0] dec_ndst,
  input  logic [CW-1:0]   rob_free,
  input  logic [CW-1:0]   iq_free,
  input  logic [CW-1:0]   preg_free,
  input  logic            down_stall,
  input  logic            cm_squash,
  input  logic            rob_squashing,
  output logic            stall_o,
  output logic [W-1:0]    fwd_mask,
  output logic            fwd_from_skid,
  output logic [1:0]      state_o,
  output logic [LW-1:0]   skid_lvl
);
  rn_state_e st_q, st_n;
  logic [IW-1:0] idx_q, idx_n;

  // named internal events
  logic ev_sqany, ev_push, ev_pop, ev_clr, ev_admit, ev_full;
  logic [GW-1:0] head_g, dec_g;
  logic [IW-1:0] src_cnt;
  logic [W-1:0]  src_sq;
  logic [W*DW-1:0] src_nd;
  logic [W-1:0]  adm_mask;
  logic [IW-1:0] adm_n, lim;
  logic          adm_short;
  int u_rob, u_iq, u_min, avail;

  assign ev_sqany = cm_squash || rob_squashing;
  assign dec_g    = {dec_cnt, dec_sq, dec_ndst};

  always_comb begin
    if (st_q == RN_UNB) begin
      src_cnt = head_g[GW-1 -: IW];
      src_sq  = head_g[W*DW +: W];
      src_nd  = head_g[W*DW-1:0];
    end else begin
      src_cnt = dec_cnt;
      src_sq  = dec_sq;
      src_nd  = dec_ndst;
    end
    u_rob = usable_credit(int'(rob_free), W, FB_DELAY);
    u_iq  = usable_credit(int'(iq_free), W, FB_DELAY);
    u_min = min_int(u_rob, u_iq);
    avail = (src_cnt > idx_q) ? int'(src_cnt) - int'(idx_q) : 0;
    lim   = (u_min <= 0) ? '0 : IW'(min_int(u_min, avail));
  end

  rn_admit #(.W(W), .DW(DW), .IW(IW), .CW(CW)) u_admit (
    .sq(src_sq), .nd(src_nd), .start(idx_q), .lim(lim), .preg(preg_free),
    .mask(adm_mask), .ncons(adm_n), .preg_short(adm_short)
  );

  rn_skid #(.GW(GW), .DEPTH(SKID_DEPTH)) u_skid (
    .clk(clk), .rst_n(rst_n), .clr(ev_clr), .push(ev_push), .pop(ev_pop),
    .din(dec_g), .head(head_g), .lvl(skid_lvl), .full(ev_full)
  );

  always_comb begin
    logic blk;
    logic [LW:0] left;
    st_n     = st_q;
    idx_n    = idx_q;
    ev_push  = 1'b0;
    ev_pop   = 1'b0;
    ev_clr   = 1'b0;
    ev_admit = 1'b0;
    stall_o  = 1'b0;
    blk      = 1'b0;
    left     = '0;
    if (ev_sqany) begin
      st_n   = RN_SQ;
      ev_clr = 1'b1;
      idx_n  = '0;
    end else if (st_q == RN_BLK) begin
      stall_o = 1'b1;
      ev_push = (dec_cnt != '0);
      if (!down_stall && u_rob > 0 && u_iq > 0 && preg_free != '0) begin
        if (skid_lvl == '0 && !ev_push) begin
          st_n  = RN_RUN;
          idx_n = '0;
        end else begin
          st_n = RN_UNB;
        end
      end
    end else begin
      if (down_stall) begin
        blk = 1'b1;
      end else if (avail == 0) begin
        blk = 1'b0;
      end else if (u_min <= 0) begin
        blk = 1'b1;
      end else begin
        ev_admit = 1'b1;
        blk      = (u_min < avail) || adm_short;
      end
      if (blk) begin
        ev_push = (dec_cnt != '0);
        st_n    = RN_BLK;
        stall_o = 1'b1;
        idx_n   = ev_admit ? idx_q + adm_n : idx_q;
      end else begin
        idx_n = '0;
        if (st_q == RN_UNB) begin
          ev_pop  = 1'b1;
          ev_push = (dec_cnt != '0);
          left    = (LW+1)'(skid_lvl) - (LW+1)'(1) + (LW+1)'(ev_push);
          stall_o = (left != '0);
          st_n    = (left != '0) ? RN_UNB : RN_RUN;
        end else begin
          st_n = RN_RUN;
        end
      end
    end
  end

  assign fwd_mask      = ev_admit ? adm_mask : '0;
  assign fwd_from_skid = (st_q == RN_UNB);
  assign state_o       = st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RN_RUN;
      idx_q <= '0;
    end else begin
      st_q  <= st_n;
      idx_q <= idx_n;
    end
  end
endmodule

// File: rtl/rn_ctrl_chk.sv
module rn_ctrl_chk #(
  parameter int W  = 4,
  parameter int IW = 3,
  parameter int LW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    st,
  input logic [IW-1:0] idx,
  input logic [LW-1:0] lvl,
  input logic          stall,
  input logic [W-1:0]  mask,
  input logic [W-1:0]  src_sq,
  input logic          sqany,
  input logic          push,
  input logic          pop,
  input logic          full
);
  // R9
  sq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sqany |=> (lvl == '0 && st == 2'd3));
  // R6
  blk_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd1 && !sqany) |-> stall);
  // R6
  blk_nofwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd1) |-> (mask == '0));
  // R4
  sq_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask & src_sq) == '0);
  // R8
  run_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0) |-> (lvl == '0));
  // R10
  idx_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0) |-> (idx == '0));
  // R12
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && full && !pop));
endmodule

bind rn_ctrl rn_ctrl_chk #(.W(W), .IW(IW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .st(st_q), .idx(idx_q), .lvl(skid_lvl),
  .stall(stall_o), .mask(fwd_mask), .src_sq(src_sq), .sqany(ev_sqany),
  .push(ev_push), .pop(ev_pop), .full(ev_full)
);

// File: tb/sim_rn_ctrl.sv
`timescale 1ns/1ps
module sim_rn_ctrl;
  localparam int W = 4, DW = 2, CW = 6, FBD = 2, DEPTH = 4;
  localparam int IW = $clog2(W + 1), LW = $clog2(DEPTH + 1);
  localparam int NCYC = 4000;

  typedef struct { int cnt; bit sq[W]; int nd[W]; } bgrp_t;

  logic clk = 0, rst_n = 0;
  logic [IW-1:0] dec_cnt = '0;
  logic [W-1:0] dec_sq = '0;
  logic [W*DW-1:0] dec_ndst = '0;
  logic [CW-1:0] rob_free = '0, iq_free = '0, preg_free = '0;
  logic down_stall = 0, cm_squash = 0, rob_squashing = 0;
  logic stall_o, fwd_from_skid;
  logic [W-1:0] fwd_mask;
  logic [1:0] state_o;
  logic [LW-1:0] skid_lvl;

  always #5 clk = ~clk;

  rn_ctrl #(.W(W), .DW(DW), .CW(CW), .FB_DELAY(FBD), .SKID_DEPTH(DEPTH)) u0 (.*);

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // reference model state
  int m_st = 0, m_idx = 0;
  bgrp_t q[$];
  bgrp_t g_in;
  // model results for the current cycle
  int e_mask, e_stall, e_nst, e_nidx;
  bit e_push, e_pop, e_clr;
  string tag;

  task automatic chk(input bit ok, input string t, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d (t=%0t)", t, what, act, exp, $time);
    end
  endtask

  task automatic model_eval();
    int urob, uiq, umin, avail, lim, rem, n, s, left;
    bit blk, sqany;
    bgrp_t src;
    urob = int'(rob_free) - W * FBD;
    uiq  = int'(iq_free) - W * FBD;
    umin = (urob < uiq) ? urob : uiq;
    sqany = cm_squash || rob_squashing;
    e_mask = 0; e_stall = 0; e_nst = m_st; e_nidx = m_idx;
    e_push = 0; e_pop = 0; e_clr = 0; tag = "R10";
    if (sqany) begin
      e_nst = 3; e_clr = 1; e_nidx = 0; tag = "R9";
    end else if (m_st == 1) begin
      tag = "R7"; e_stall = 1; e_push = (g_in.cnt > 0);
      if (!down_stall && urob > 0 && uiq > 0 && preg_free != 0) begin
        if (q.size() == 0 && !e_push) begin e_nst = 0; e_nidx = 0; end
        else e_nst = 2;
      end
    end else begin
      src = (m_st == 2) ? q[0] : g_in;
      avail = src.cnt - m_idx; if (avail < 0) avail = 0;
      blk = 0; n = 0;
      if (down_stall) begin blk = 1; tag = "R11"; end
      else if (avail == 0) blk = 0;
      else if (umin <= 0) begin blk = 1; tag = "R2"; end
      else begin
        lim = (umin < avail) ? umin : avail;
        if (umin < avail) begin blk = 1; tag = "R3"; end
        rem = int'(preg_free);
        for (int k = 0; k < lim; k++) begin
          s = m_idx + k;
          if (src.sq[s]) begin n++; tag = "R4"; end
          else if (src.nd[s] > rem) begin blk = 1; tag = "R5"; break; end
          else begin e_mask |= (1 << s); rem -= src.nd[s]; n++; end
        end
      end
      if (blk) begin
        e_push = (g_in.cnt > 0); e_nst = 1; e_stall = 1; e_nidx = m_idx + n;
        if (tag == "R10") tag = "R6";
      end else begin
        e_nidx = 0;
        if (m_st == 2) begin
          tag = "R8"; e_pop = 1; e_push = (g_in.cnt > 0);
          left = q.size() - 1 + int'(e_push);
          e_stall = (left > 0); e_nst = (left > 0) ? 2 : 0;
        end else e_nst = 0;
      end
    end
  endtask

  task automatic model_commit();
    if (e_clr) q.delete();
    else begin
      if (e_pop) void'(q.pop_front());
      if (e_push) q.push_back(g_in);
    end
    m_st = e_nst; m_idx = e_nidx;
  endtask

  task automatic drive(input bit send);
    int r;
    g_in.cnt = send ? $urandom_range(0, W) : 0;
    for (int j = 0; j < W; j++) begin
      g_in.sq[j] = (j < g_in.cnt) && ($urandom_range(0, 4) == 0);
      g_in.nd[j] = (j < g_in.cnt) ? $urandom_range(0, 2) : 0;
      dec_sq[j] = g_in.sq[j];
      dec_ndst[j*DW +: DW] = DW'(g_in.nd[j]);
    end
    dec_cnt = IW'(g_in.cnt);
    rob_free = CW'($urandom_range(0, 16));
    iq_free = CW'($urandom_range(4, 18));
    preg_free = CW'($urandom_range(0, 6));
    r = $urandom_range(0, 99);
    down_stall = (r < 10);
    cm_squash = (r >= 96);
    rob_squashing = (r >= 93 && r < 96);
  endtask

  initial begin
    bit last_stall;
    bit send;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #3;
    // R1 reset state
    chk(state_o == 2'd0, "R1", "state", int'(state_o), 0);
    chk(stall_o == 1'b0, "R1", "stall", int'(stall_o), 0);
    chk(skid_lvl == '0, "R1", "skid_lvl", int'(skid_lvl), 0);
    chk(fwd_mask == '0, "R1", "fwd_mask", int'(fwd_mask), 0);
    last_stall = 0;
    for (int c = 0; c < NCYC; c++) begin
      @(negedge clk);
      send = !last_stall || (q.size() < DEPTH - 1 && $urandom_range(0, 4) == 0);
      drive(send);
      #3;
      model_eval();
      chk(int'(stall_o) == e_stall, tag, "stall", int'(stall_o), e_stall);
      chk(int'(fwd_mask) == e_mask, tag, "fwd_mask", int'(fwd_mask), e_mask);
      chk(fwd_from_skid == (m_st == 2), "R8", "fwd_from_skid", int'(fwd_from_skid), int'(m_st == 2));
      chk(int'(state_o) == m_st, tag, "state", int'(state_o), m_st);
      chk(int'(skid_lvl) == q.size(), "R6", "skid_lvl", int'(skid_lvl), q.size());
      chk(q.size() <= DEPTH, "R12", "skid occupancy", q.size(), DEPTH);
      last_stall = stall_o;
      @(posedge clk);
      model_commit();
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule